// File: doc/BRIEF.md
# Event-Triggered Micro DMA Channel

This block is a single DMA channel. It moves one small unit of data each time a chosen interrupt event fires, and the CPU does nothing per transfer. Software first loads a source address, a destination address, a transfer count, a mode byte and a 5-bit trigger code. From then on, every event whose vector number equals the trigger code causes one transfer of 1, 2 or 4 bytes from the source to the destination. After the transfer the channel steps the addresses as the mode selects and lowers the count by one. The transfer that uses up the count raises a one-cycle completion interrupt.

The channel drives a byte-wide synchronous memory master port. A read returns its data in the cycle after the request, and each byte is copied as a read followed by a write. A counter mode moves no data at all and only advances the source address, which lets the channel count events. The current addresses and count are visible on output ports at all times.

Top module: `evdma_channel`

## Requirements
- R1: After reset the channel is idle and disarmed: `busy_o`, `done_irq`, `err_o` and `mem_req` are low, and the source, destination and count all read 0.
- R2: A transfer starts only on a clock edge where `evt_valid` is high, `evt_vector` equals the programmed trigger code, the channel is armed, no error is flagged and no transfer is in progress. Events with any other vector have no effect, and events that arrive while a transfer is running are dropped.
- R3: Mode bits [1:0] set the transfer size: 0 gives 1 byte, 1 gives 2 bytes and 2 gives 4 bytes. Byte i is read from source+i and then written to destination+i, in ascending (little-endian) order. Each write carries the data returned by the read in the cycle before it.
- R4: Mode bits [4:2] control the addresses after each transfer, with a step equal to the transfer size: 0 adds the step to the destination, 1 subtracts it from the destination, 2 adds it to the source, 3 subtracts it from the source, and 4 leaves both addresses unchanged. Address arithmetic wraps at 24 bits.
- R5: Address-control code 5 is counter mode. A trigger makes no memory access and adds exactly 1 to the source address.
- R6: Each transfer lowers the count by one. Writing the count register arms the channel. A count of 0 means 65536, so a transfer that starts from 0 leaves 0xFFFF and raises no completion.
- R7: The transfer that starts with the count at 1 ends with `done_irq` high for exactly one cycle and leaves the channel disarmed. Later matching events do nothing until the count is written again.
- R8: `err_o` is set and triggers are ignored if the last mode write had size code 3, an address-control code of 6 or 7, or any of bits [7:5] set. It is also set if the last trigger-code write had any of bits [7:5] set. Each cause clears only when its own register is written with a valid value.
- R9: A register is written when `cfg_we` is high. `cfg_sel` selects the register: 0 source, 1 destination, 2 count, 3 mode, 4 trigger code. Only the low 24 bits of an address write are kept, and `src_o`, `dst_o` and `count_o` show the current values. If a register write and the end of a transfer fall in the same cycle, the register write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 src, 1 dst, 2 count, 3 mode, 4 trigger) |
| cfg_wdata | input | 32 | Register write data |
| evt_valid | input | 1 | Interrupt event present this cycle |
| evt_vector | input | 5 | Vector number of the event |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| done_irq | output | 1 | One-cycle completion interrupt |
| err_o | output | 1 | Sticky configuration error |
| busy_o | output | 1 | Transfer in progress |
| src_o | output | 24 | Current source address |
| dst_o | output | 24 | Current destination address |
| count_o | output | 16 | Current remaining count |

## Verification
Some rules are checked by assertions on every cycle: a memory write always follows a read, each transfer lowers the count by exactly one, the channel disarms after its final transfer, the completion pulse lasts one cycle, a transfer never starts without a matching event, and an idle channel with an error never issues a request. Other behaviour can only be shown by the bench's scenarios. These are the byte placement for each size, the address step for each control code, the wrap at 24 bits, the count of 0 standing for 65536, counter mode making no memory access, dropped events, and the clearing of errors by valid rewrites.

// File: rtl/evdma_pkg.sv
// Package: shared constants, types and helpers for the event-triggered DMA channel.
// Assumes the mode-byte layout: size code in bits [1:0], address control in bits [4:2].
package evdma_pkg;
    localparam logic [2:0] SEL_SRC   = 3'd0;
    localparam logic [2:0] SEL_DST   = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_MODE  = 3'd3;
    localparam logic [2:0] SEL_VEC   = 3'd4;

    localparam logic [2:0] ACTL_DST_INC = 3'd0;
    localparam logic [2:0] ACTL_DST_DEC = 3'd1;
    localparam logic [2:0] ACTL_SRC_INC = 3'd2;
    localparam logic [2:0] ACTL_SRC_DEC = 3'd3;
    localparam logic [2:0] ACTL_FIXED   = 3'd4;
    localparam logic [2:0] ACTL_COUNT   = 3'd5;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} eng_state_t;

    // Number of bytes a legal size code stands for.
    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // A mode byte is illegal on a reserved size, a reserved control code or any high bit set.
    function automatic logic mode_bad(input logic [7:0] m);
        return (m[1:0] == 2'd3) || (m[4:2] > ACTL_COUNT) || (|m[7:5]);
    endfunction
endpackage

// File: rtl/evdma_cfg.sv
// Register file of the channel: addresses, count, mode, trigger code, arm and error flags.
// Assumes that a register write in the same cycle as an engine update takes priority.
module evdma_cfg
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int VEC_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              upd_en,
    input  logic [ADDR_W-1:0] upd_src,
    input  logic [ADDR_W-1:0] upd_dst,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [7:0]        mode_q,
    output logic [VEC_W-1:0]  vec_q,
    output logic              armed_q,
    output logic              err
);
    logic err_mode_q;
    logic err_vec_q;

    // Register writes from software, otherwise the address and count update at the end of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q      <= '0;
            dst_q      <= '0;
            cnt_q      <= '0;
            mode_q     <= '0;
            vec_q      <= '0;
            armed_q    <= 1'b0;
            err_mode_q <= 1'b0;
            err_vec_q  <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_SRC:   src_q <= cfg_wdata[ADDR_W-1:0];
                SEL_DST:   dst_q <= cfg_wdata[ADDR_W-1:0];
                SEL_COUNT: begin
                    cnt_q   <= cfg_wdata[CNT_W-1:0];
                    armed_q <= 1'b1;
                end
                SEL_MODE: begin
                    mode_q     <= cfg_wdata[7:0];
                    err_mode_q <= mode_bad(cfg_wdata[7:0]);
                end
                SEL_VEC: begin
                    vec_q     <= cfg_wdata[VEC_W-1:0];
                    err_vec_q <= |cfg_wdata[7:VEC_W];
                end
                default: ;
            endcase
        end else if (upd_en) begin
            src_q <= upd_src;
            dst_q <= upd_dst;
            cnt_q <= cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) armed_q <= 1'b0;
        end
    end

    // Either sticky cause blocks the channel.
    always_comb err = err_mode_q | err_vec_q;

    // R6: an undisturbed update lowers the count by exactly one.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cfg_we) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R7: the final transfer leaves the channel disarmed.
    a_r7_disarm_last: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !cfg_we && cnt_q == CNT_W'(1)) |=> !armed_q);
endmodule

// File: rtl/evdma_engine.sv
// Transfer sequencer: issues byte reads and writes for one transfer, then computes the address update.
// Assumes read data arrives one cycle after a read request. Address and count registers stay untouched while busy.
module evdma_engine
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size_code,
    input  logic [2:0]        actl_code,
    input  logic [ADDR_W-1:0] src_i,
    input  logic [ADDR_W-1:0] dst_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [7:0]        mem_rdata,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_src,
    output logic [ADDR_W-1:0] upd_dst,
    output logic              done_irq
);
    eng_state_t        state_q;
    logic [1:0]        size_q;
    logic [2:0]        actl_q;
    logic [1:0]        idx_q;
    logic [2:0]        nbytes;
    logic [1:0]        last_idx;
    logic [ADDR_W-1:0] step;

    // Per-transfer byte count, last byte index and address step.
    always_comb begin
        nbytes   = size_bytes(size_q);
        last_idx = 2'(nbytes - 3'd1);
        step     = (actl_q == ACTL_COUNT) ? ADDR_W'(1) : ADDR_W'(nbytes);
    end

    // Sequencer: idle, then read/write pairs per byte, then a final update cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            size_q  <= '0;
            actl_q  <= '0;
            idx_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start) begin
                    size_q  <= size_code;
                    actl_q  <= actl_code;
                    idx_q   <= '0;
                    state_q <= (actl_code == ACTL_COUNT) ? ST_FIN : ST_RD;
                end
                ST_RD: state_q <= ST_WR;
                ST_WR: begin
                    if (idx_q == last_idx) state_q <= ST_FIN;
                    else begin
                        idx_q   <= idx_q + 2'd1;
                        state_q <= ST_RD;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Memory port: the read address comes from the source, the write address from the destination, the byte index is added.
    always_comb begin
        mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we    = (state_q == ST_WR);
        mem_addr  = (state_q == ST_WR) ? dst_i + ADDR_W'(idx_q) : src_i + ADDR_W'(idx_q);
        mem_wdata = mem_rdata;
        busy      = (state_q != ST_IDLE);
    end

    // Address update from the latched control code, and the completion pulse.
    always_comb begin
        upd_en  = (state_q == ST_FIN);
        upd_src = src_i;
        upd_dst = dst_i;
        case (actl_q)
            ACTL_DST_INC: upd_dst = dst_i + step;
            ACTL_DST_DEC: upd_dst = dst_i - step;
            ACTL_SRC_INC,
            ACTL_COUNT:   upd_src = src_i + step;
            ACTL_SRC_DEC: upd_src = src_i - step;
            default: ;
        endcase
        done_irq = upd_en && (cnt_i == CNT_W'(1));
    end

    // R3: every byte write is preceded by its read in the previous cycle.
    a_r3_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $past(mem_req && !mem_we));
    // R7: the completion interrupt lasts a single cycle.
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq);
endmodule

// File: rtl/evdma_channel.sv
// Top of the event-triggered DMA channel: matches events against the trigger code and joins registers to the sequencer.
// Assumes events are single-cycle qualifiers; an event that is not accepted is lost.
module evdma_channel
    import evdma_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 16,
    parameter int VEC_W  = 5,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              evt_valid,
    input  logic [VEC_W-1:0]  evt_vector,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              done_irq,
    output logic              err_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  count_o
);
    logic [7:0]        mode_q;
    logic [VEC_W-1:0]  vec_q;
    logic              armed_q;
    logic              err;
    logic              start;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_src;
    logic [ADDR_W-1:0] upd_dst;

    evdma_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .VEC_W(VEC_W), .WORD_W(WORD_W)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst),
        .src_q(src_o), .dst_q(dst_o), .cnt_q(count_o), .mode_q(mode_q), .vec_q(vec_q),
        .armed_q(armed_q), .err(err)
    );

    // Accept a matching event only when the channel is armed, healthy and idle.
    always_comb start = evt_valid && (evt_vector == vec_q) && armed_q && !err && !busy_o;

    evdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .size_code(mode_q[1:0]), .actl_code(mode_q[4:2]),
        .src_i(src_o), .dst_i(dst_o), .cnt_i(count_o), .mem_rdata(mem_rdata),
        .busy(busy_o), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst),
        .done_irq(done_irq)
    );

    // Expose the sticky error.
    always_comb err_o = err;

    // R2: a transfer begins only after a matching event on an armed, error-free channel.
    a_r2_start_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(evt_valid && evt_vector == vec_q && armed_q && !err));
    // R8: an idle channel with an error issues no memory request next cycle.
    a_r8_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !busy_o) |=> !mem_req);
endmodule

// File: tb/evdma_channel_tb_top.sv
// Directed bench for the event-triggered DMA channel, with a byte memory model that has one-cycle read latency.
module evdma_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        evt_valid = 1'b0;
    logic [4:0]  evt_vector = '0;
    logic        mem_req, mem_we, done_irq, err_o, busy_o;
    logic [23:0] mem_addr, src_o, dst_o;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [15:0] count_o;

    int checks = 0;
    int fails = 0;
    int done_cnt = 0;
    int req_cnt = 0;
    logic [7:0] mem [0:1023];

    always #10 clk = ~clk;

    evdma_channel dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .evt_valid(evt_valid), .evt_vector(evt_vector),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done_irq(done_irq), .err_o(err_o), .busy_o(busy_o),
        .src_o(src_o), .dst_o(dst_o), .count_o(count_o)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a * 7 + 3);
    endfunction

    // Memory model with a preload during reset, and counters for requests and completion pulses.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= init_val(i);
        end else begin
            if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
            if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
            if (mem_req) req_cnt <= req_cnt + 1;
            if (done_irq) done_cnt <= done_cnt + 1;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Hold an event for n cycles, then wait for the channel to go idle.
    task automatic fire(input logic [4:0] vec, input int n);
        @(negedge clk);
        evt_valid = 1'b1; evt_vector = vec;
        for (int k = 0; k < n; k++) @(negedge clk);
        evt_valid = 1'b0;
        for (int k = 0; k < 40 && busy_o; k++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "busy", 32'(busy_o), 0);
        chk("R1", "done", 32'(done_irq), 0);
        chk("R1", "err", 32'(err_o), 0);
        chk("R1", "req", 32'(mem_req), 0);
        chk("R1", "count", 32'(count_o), 0);
        chk("R1", "src", 32'(src_o), 0);
        fire(5'h00, 1);
        chk("R1", "disarmed no request", 32'(req_cnt), 0);
    endtask

    task automatic t_two_byte();
        int d0;
        wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd3, 32'd9); wr(3'd4, 32'h10); wr(3'd2, 32'd3);
        d0 = done_cnt;
        fire(5'h10, 1);
        chk("R3", "byte0", 32'(mem[10'h200]), 32'(init_val(32'h100)));
        chk("R3", "byte1", 32'(mem[10'h201]), 32'(init_val(32'h101)));
        chk("R4", "src inc by 2", 32'(src_o), 32'h102);
        chk("R4", "dst held", 32'(dst_o), 32'h200);
        chk("R6", "count", 32'(count_o), 2);
        chk("R3", "four accesses", 32'(req_cnt), 4);
        fire(5'h11, 1);
        chk("R2", "wrong vector count", 32'(count_o), 2);
        chk("R2", "wrong vector no req", 32'(req_cnt), 4);
        fire(5'h10, 1);
        chk("R3", "second byte0", 32'(mem[10'h200]), 32'(init_val(32'h102)));
        fire(5'h10, 1);
        chk("R7", "one done pulse", 32'(done_cnt - d0), 1);
        chk("R7", "count zero", 32'(count_o), 0);
        fire(5'h10, 1);
        chk("R7", "disarmed src", 32'(src_o), 32'h106);
        chk("R7", "no second done", 32'(done_cnt - d0), 1);
        wr(3'd2, 32'd1);
        fire(5'h10, 1);
        chk("R7", "rearmed runs", 32'(src_o), 32'h108);
        chk("R7", "rearmed done", 32'(done_cnt - d0), 2);
    endtask

    task automatic t_sizes();
        wr(3'd0, 32'h300); wr(3'd1, 32'h340); wr(3'd3, 32'h02); wr(3'd4, 32'h0B); wr(3'd2, 32'd10);
        fire(5'h0B, 3);
        for (int i = 0; i < 4; i++)
            chk("R3", "four-byte order", 32'(mem[10'h340 + i]), 32'(init_val(32'h300 + i)));
        chk("R4", "dst inc by 4", 32'(dst_o), 32'h344);
        chk("R2", "busy event dropped", 32'(count_o), 9);
        wr(3'd1, 32'h380); wr(3'd3, 32'h04);
        fire(5'h0B, 1);
        chk("R4", "dst dec by 1", 32'(dst_o), 32'h37F);
        chk("R3", "one byte", 32'(mem[10'h380]), 32'(init_val(32'h300)));
        wr(3'd0, 32'h3A0); wr(3'd3, 32'h0D);
        fire(5'h0B, 1);
        chk("R4", "src dec by 2", 32'(src_o), 32'h39E);
        wr(3'd3, 32'h10);
        fire(5'h0B, 1);
        chk("R4", "fixed src", 32'(src_o), 32'h39E);
        chk("R4", "fixed dst", 32'(dst_o), 32'h37F);
        chk("R6", "count after four", 32'(count_o), 6);
    endtask

    task automatic t_counter();
        int r0, d0;
        wr(3'd0, 32'hABFFFFFF);
        chk("R9", "src low 24 bits", 32'(src_o), 32'hFFFFFF);
        wr(3'd1, 32'h12345678);
        chk("R9", "dst low 24 bits", 32'(dst_o), 32'h345678);
        wr(3'd3, 32'h14); wr(3'd4, 32'h0C); wr(3'd2, 32'd0);
        r0 = req_cnt; d0 = done_cnt;
        fire(5'h0C, 1);
        chk("R5", "src wraps to 0", 32'(src_o), 0);
        chk("R5", "no memory access", 32'(req_cnt - r0), 0);
        chk("R6", "0 means 65536", 32'(count_o), 32'hFFFF);
        chk("R6", "no done from 0", 32'(done_cnt - d0), 0);
        fire(5'h0C, 1);
        chk("R5", "src plus one", 32'(src_o), 1);
    endtask

    task automatic t_errors();
        int r0;
        wr(3'd0, 32'h100); wr(3'd3, 32'h03); wr(3'd4, 32'h12); wr(3'd2, 32'd5);
        chk("R8", "size 3 error", 32'(err_o), 1);
        r0 = req_cnt;
        fire(5'h12, 1);
        chk("R8", "blocked count", 32'(count_o), 5);
        chk("R8", "blocked req", 32'(req_cnt - r0), 0);
        wr(3'd3, 32'h1C);
        chk("R8", "ctl 7 error", 32'(err_o), 1);
        wr(3'd3, 32'h20);
        chk("R8", "high bits error", 32'(err_o), 1);
        wr(3'd3, 32'h08);
        chk("R8", "cleared", 32'(err_o), 0);
        wr(3'd4, 32'h32);
        chk("R8", "vector high bits", 32'(err_o), 1);
        wr(3'd4, 32'h12);
        chk("R8", "vector cleared", 32'(err_o), 0);
        fire(5'h12, 1);
        chk("R8", "runs after clear", 32'(count_o), 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_two_byte();
        t_sizes();
        t_counter();
        t_errors();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule